// File: doc/BRIEF.md
# Serial ADC Channel Sequencer Controller

This block is the digital control side of an eight-input, 12-bit sampling converter with a serial port. An active-low select frames each transfer. While select is low, one bit moves per rising edge of `clk_i`, which serves as the serial clock. Each frame carries a 16-bit control word in on `din_i`, most significant bit first. During the same frame, a result word goes out on `dout_o`.

When select falls, the block picks the channel for that conversion and drives it on `chan_o` to an external sample source. The source returns a 12-bit value on `sample_i`. The block latches that value and sends it back with the channel number. Two control bits choose the channel policy: a fixed single channel, or a looping sweep from channel 0 up to a programmed limit. A third combination rewrites range, coding and power mode while a running sweep carries on undisturbed.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `chan_o` is 0, `pm_o` is 2'b11, `range_o` is 0, `dout_o` is 0 and coding selects two's complement.
- R2: The first complete 16-bit frame after reset is a dummy and never changes the control register, whatever `din_i` holds.
- R3: Control word bit positions, with bit 15 sent first: 15 write, 14 sequence, 12..10 address (12 is MSB), 9..8 power mode, 7 shadow, 5 range, 4 coding. Bits 13, 6 and 3..0 are don't-care. A frame with bit 15 = 0 leaves power mode, range, coding and channel policy unchanged.
- R4: Result word, sent first bit first, is a 0, then the 3-bit channel number (MSB first), then the 12-bit sample (MSB first). The sample is latched from `sample_i` at the rising edge that ends the fourth bit of the frame.
- R5: With coding = 1, the 12-bit field is the sample unchanged. With coding = 0, it is the sample with its MSB inverted.
- R6: A write with sequence = 0 selects single mode: every later frame converts the written address.
- R7: A write with sequence = 1 and shadow = 1 and address N starts a sweep. The next frame converts channel 0, and later frames convert 1, 2, …, N and then wrap to 0.
- R8: A write with sequence = 1 and shadow = 0 updates power mode, range and coding only. The address field is ignored, and the sweep or single channel continues unchanged.
- R9: `pm_o` and `range_o` change only at the rising edge that completes the 16th bit of an accepted write frame.
- R10: If select rises before 16 bits have been sent, the frame writes nothing. The channel step taken when that frame began still stands.
- R11: `chan_o` changes only at the first rising edge after select falls, and stays constant for the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Frame select, active low |
| din_i | input | 1 | Serial control word, MSB first |
| sample_i | input | 12 | Sample value for the channel on `chan_o` |
| chan_o | output | 3 | Channel being converted |
| dout_o | output | 1 | Serial result word |
| pm_o | output | 2 | Power mode field |
| range_o | output | 1 | Input range select |

## Verification
The hardest case to reach is a sweep restart followed by a shadow-free write that lands mid-sweep. The write must change coding and power mode, and the loop must neither restart nor jump to the new address. Directed frames start a sweep with a small limit, run it past a wrap, then send a sequence=1/shadow=0 write that carries a different address. Each following result word must still carry the next channel in the loop and must use the new coding. Random frames then mix all three policies, write-disabled words and aborted frames.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned CH_W    = 3;
  localparam int unsigned RES_W   = 12;
  localparam int unsigned FRAME_W = 1 + CH_W + RES_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
  localparam int unsigned PM_W    = 2;

  // control word bit positions (MSB arrives first)
  localparam int unsigned WR_POS   = 15;
  localparam int unsigned SEQ_POS  = 14;
  localparam int unsigned ADDR_MSB = 12;
  localparam int unsigned PM_MSB   = 9;
  localparam int unsigned SHD_POS  = 7;
  localparam int unsigned RNG_POS  = 5;
  localparam int unsigned COD_POS  = 4;

  typedef struct packed {
    logic            seq;
    logic            shadow;
    logic [CH_W-1:0] addr;
    logic [PM_W-1:0] pm;
    logic            range_sel;
    logic            coding;
  } ctrl_t;
endpackage

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
  import adc_seq_pkg::*;
#(
  parameter int unsigned FW = FRAME_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  output logic [CW-1:0] cnt_o,
  output logic          start_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LAST = CW'(FW - 1);
  localparam logic [CW-1:0] FULL = CW'(FW);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cs_ni)        cnt_q <= '0;
    else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign start_o = !cs_ni && (cnt_q == '0);
  assign done_o  = !cs_ni && (cnt_q == LAST);
endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_seq_pkg::*;
#(
  parameter int unsigned FW = FRAME_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            din_i,
  input  logic [CW-1:0]   cnt_i,
  input  logic            done_i,
  output ctrl_t           stg_o,
  output logic            wr_o,
  output logic [PM_W-1:0] pm_o,
  output logic            range_o,
  output logic            coding_o
);
  // bit index within the frame at which each field arrives
  localparam logic [CW-1:0] K_WR   = CW'(FW - 1 - WR_POS);
  localparam logic [CW-1:0] K_SEQ  = CW'(FW - 1 - SEQ_POS);
  localparam logic [CW-1:0] K_ADDR = CW'(FW - 1 - ADDR_MSB);
  localparam logic [CW-1:0] K_PM   = CW'(FW - 1 - PM_MSB);
  localparam logic [CW-1:0] K_SHD  = CW'(FW - 1 - SHD_POS);
  localparam logic [CW-1:0] K_RNG  = CW'(FW - 1 - RNG_POS);
  localparam logic [CW-1:0] K_COD  = CW'(FW - 1 - COD_POS);
  localparam logic [CW-1:0] FULL   = CW'(FW);

  ctrl_t           stg_q;
  logic            stg_wr_q;
  logic            armed_q;
  logic [PM_W-1:0] pm_q;
  logic            rng_q;
  logic            cod_q;
  logic            bit_en;

  assign bit_en = !cs_ni && (cnt_i != FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q    <= '0;
      stg_wr_q <= 1'b0;
    end else if (bit_en) begin
      if (cnt_i == K_WR)  stg_wr_q     <= din_i;
      if (cnt_i == K_SEQ) stg_q.seq    <= din_i;
      if (cnt_i >= K_ADDR && cnt_i < K_ADDR + CW'(CH_W))
        stg_q.addr <= {stg_q.addr[CH_W-2:0], din_i};
      if (cnt_i >= K_PM && cnt_i < K_PM + CW'(PM_W))
        stg_q.pm <= {stg_q.pm[PM_W-2:0], din_i};
      if (cnt_i == K_SHD) stg_q.shadow    <= din_i;
      if (cnt_i == K_RNG) stg_q.range_sel <= din_i;
      if (cnt_i == K_COD) stg_q.coding    <= din_i;
    end
  end

  assign wr_o = done_i && armed_q && stg_wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      pm_q    <= '1;
      rng_q   <= 1'b0;
      cod_q   <= 1'b0;
    end else begin
      if (done_i) armed_q <= 1'b1;
      if (wr_o) begin
        pm_q  <= stg_q.pm;
        rng_q <= stg_q.range_sel;
        cod_q <= stg_q.coding;
      end
    end
  end

  assign stg_o    = stg_q;
  assign pm_o     = pm_q;
  assign range_o  = rng_q;
  assign coding_o = cod_q;
endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned AW = CH_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic          seq_i,
  input  logic          shadow_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] chan_o
);
  logic          sweep_q;
  logic          restart_q;
  logic [AW-1:0] last_q;
  logic [AW-1:0] single_q;
  logic [AW-1:0] chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sweep_q   <= 1'b0;
      restart_q <= 1'b0;
      last_q    <= '0;
      single_q  <= '0;
      chan_q    <= '0;
    end else begin
      // write and frame start never share an edge
      if (wr_i) begin
        if (!seq_i) begin
          sweep_q  <= 1'b0;
          single_q <= addr_i;
        end else if (shadow_i) begin
          sweep_q   <= 1'b1;
          restart_q <= 1'b1;
          last_q    <= addr_i;
        end
      end else if (start_i) begin
        if (!sweep_q) begin
          chan_q <= single_q;
        end else if (restart_q) begin
          chan_q    <= '0;
          restart_q <= 1'b0;
        end else begin
          chan_q <= (chan_q == last_q) ? '0 : chan_q + 1'b1;
        end
      end
    end
  end

  assign chan_o = chan_q;
endmodule

// File: rtl/adc_result_tx.sv
module adc_result_tx
  import adc_seq_pkg::*;
#(
  parameter int unsigned FW = FRAME_W,
  parameter int unsigned CW = CNT_W,
  parameter int unsigned AW = CH_W,
  parameter int unsigned RW = RES_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] chan_i,
  input  logic [RW-1:0] sample_i,
  input  logic          coding_i,
  output logic          dout_o
);
  logic [RW-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else if (!cs_ni && cnt_i == CW'(AW))
      res_q <= coding_i ? sample_i : {~sample_i[RW-1], sample_i[RW-2:0]};
  end

  always_comb begin
    int k;
    k = int'(cnt_i);
    dout_o = 1'b0;
    if (!cs_ni) begin
      if (k >= 1 && k <= int'(AW))       dout_o = chan_i[int'(AW) - k];
      else if (k > int'(AW) && k < int'(FW)) dout_o = res_q[int'(FW) - 1 - k];
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned AW = CH_W,
  parameter int unsigned RW = RES_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          din_i,
  input  logic [RW-1:0] sample_i,
  output logic [AW-1:0] chan_o,
  output logic          dout_o,
  output logic [1:0]    pm_o,
  output logic          range_o
);
  localparam int unsigned FW = 1 + AW + RW;
  localparam int unsigned CW = $clog2(FW + 1);

  logic [CW-1:0] bit_cnt;
  logic          frame_start;
  logic          frame_done;
  logic          wr;
  logic          coding;
  ctrl_t         stg;

  adc_frame_rx #(.FW(FW), .CW(CW)) u_rx (
    .clk_i, .rst_ni, .cs_ni,
    .cnt_o(bit_cnt), .start_o(frame_start), .done_o(frame_done)
  );

  adc_ctrl_reg #(.FW(FW), .CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .cs_ni, .din_i,
    .cnt_i(bit_cnt), .done_i(frame_done),
    .stg_o(stg), .wr_o(wr), .pm_o(pm_o), .range_o(range_o), .coding_o(coding)
  );

  adc_chan_seq #(.AW(AW)) u_seq (
    .clk_i, .rst_ni, .start_i(frame_start), .wr_i(wr),
    .seq_i(stg.seq), .shadow_i(stg.shadow), .addr_i(stg.addr),
    .chan_o(chan_o)
  );

  adc_result_tx #(.FW(FW), .CW(CW), .AW(AW), .RW(RW)) u_tx (
    .clk_i, .rst_ni, .cs_ni, .cnt_i(bit_cnt), .chan_i(chan_o),
    .sample_i(sample_i), .coding_i(coding), .dout_o(dout_o)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int unsigned AW = 3,
  parameter int unsigned CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          din_i,
  input logic [AW-1:0] chan_o,
  input logic [1:0]    pm_o,
  input logic          range_o,
  input logic [CW-1:0] bit_cnt,
  input logic          frame_start,
  input logic          frame_done
);
  logic          seen_q, c_wr, c_seq, c_shd, pend_q, single_q;
  logic [AW-1:0] c_addr, saddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0; c_wr <= 1'b0; c_seq <= 1'b0; c_shd <= 1'b0;
      pend_q <= 1'b0; single_q <= 1'b1; c_addr <= '0; saddr_q <= '0;
    end else begin
      if (!cs_ni) begin
        if (bit_cnt == 0) c_wr  <= din_i;
        if (bit_cnt == 1) c_seq <= din_i;
        if (bit_cnt == 8) c_shd <= din_i;
        if (bit_cnt >= 3 && bit_cnt <= 5) c_addr <= {c_addr[AW-2:0], din_i};
      end
      if (frame_start) pend_q <= 1'b0;
      if (frame_done) begin
        seen_q <= 1'b1;
        if (seen_q && c_wr) begin
          if (!c_seq) begin
            single_q <= 1'b1; saddr_q <= c_addr; pend_q <= 1'b0;
          end else if (c_shd) begin
            single_q <= 1'b0; pend_q <= 1'b1;
          end
        end
      end
    end
  end

  // R11
  chan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt != 0) |=> $stable(chan_o));
  // R9
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done |=> $stable({pm_o, range_o}));
  // R2
  dummy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && !seen_q) |=> $stable({pm_o, range_o}));
  // R3
  no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && !c_wr) |=> $stable({pm_o, range_o}));
  // R7
  sweep_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start && pend_q) |=> (chan_o == '0));
  // R6
  single_chan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start && single_q) |=> (chan_o == saddr_q));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .din_i(din_i),
  .chan_o(chan_o), .pm_o(pm_o), .range_o(range_o), .bit_cnt(bit_cnt),
  .frame_start(frame_start), .frame_done(frame_done)
);

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        din_i = 1'b0;
  logic [11:0] sample_i;
  logic [2:0]  chan_o;
  logic        dout_o;
  logic [1:0]  pm_o;
  logic        range_o;

  logic [11:0] tab [8];
  int checks = 0, failures = 0;
  bit finished = 0;

  // reference model state
  bit       m_armed = 0, m_sweep = 0, m_restart = 0;
  int       m_last = 0, m_saddr = 0, m_ch = 0;
  int       m_pm = 3, m_rng = 0, m_cod = 0;

  always #5 clk_i = ~clk_i;
  assign sample_i = tab[chan_o];

  adc_seq_ctrl dut (
    .clk_i, .rst_ni, .cs_ni, .din_i, .sample_i,
    .chan_o, .dout_o, .pm_o, .range_o
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(bit wr, bit seq, int addr, int pm, bit shd, bit rng, bit cod);
    logic [15:0] w = '0;
    w[15] = wr; w[14] = seq; w[12:10] = 3'(addr); w[9:8] = 2'(pm);
    w[7] = shd; w[5] = rng; w[4] = cod;
    return w;
  endfunction

  function automatic int exp_res(int ch, logic [11:0] s, int cod);
    logic [11:0] v = (cod != 0) ? s : {~s[11], s[10:0]};
    return int'({1'b0, 3'(ch), v});
  endfunction

  // frame of nbits bits; full frames are checked against the model
  task automatic frame(logic [15:0] w, int nbits, string t_ch, string t_res, string t_ctl);
    logic [15:0] rx = '0;
    for (int i = 0; i < 8; i++) tab[i] = 12'($urandom);
    if (!m_sweep) m_ch = m_saddr;
    else if (m_restart) begin m_ch = 0; m_restart = 0; end
    else m_ch = (m_ch == m_last) ? 0 : m_ch + 1;
    cs_ni = 1'b0;
    for (int k = 0; k < nbits; k++) begin
      din_i = w[15-k];
      rx[15-k] = dout_o;
      @(negedge clk_i);
      if (k == 0) chk(t_ch, int'(chan_o), m_ch);
    end
    cs_ni = 1'b1;
    if (nbits == 16) begin
      chk(t_res, int'(rx), exp_res(m_ch, tab[m_ch], m_cod));
      if (m_armed && w[15]) begin
        m_pm = int'(w[9:8]); m_rng = int'(w[5]); m_cod = int'(w[4]);
        if (!w[14]) begin m_sweep = 0; m_saddr = int'(w[12:10]); end
        else if (w[7]) begin m_sweep = 1; m_restart = 1; m_last = int'(w[12:10]); end
      end
      m_armed = 1;
    end
    chk(t_ctl, int'({pm_o, range_o}), (m_pm << 1) | m_rng);
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) tab[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 chan", int'(chan_o), 0);
    chk("R1 pm", int'(pm_o), 3);
    chk("R1 range", int'(range_o), 0);
    chk("R1 dout", int'(dout_o), 0);

    // dummy frame with write set must not write; coding defaults two's
    frame(mk(1, 0, 5, 0, 0, 1, 1), 16, "R2 chan", "R1 coding", "R2 ctrl");
    // single channel, straight binary
    frame(mk(1, 0, 6, 1, 0, 1, 1), 16, "R11 chan", "R4 frame", "R9 ctrl");
    frame(16'hFFF0 & ~16'h8000, 16, "R6 chan", "R5 straight", "R3 ctrl");
    frame(mk(0, 1, 2, 0, 1, 0, 0), 16, "R6 chan", "R5 straight", "R3 ctrl");
    frame(mk(0, 0, 0, 0, 0, 0, 0), 16, "R3 chan", "R4 frame", "R3 ctrl");
    // sweep 0..3
    frame(mk(1, 1, 3, 2, 1, 0, 1), 16, "R6 chan", "R4 frame", "R9 ctrl");
    for (int i = 0; i < 6; i++) frame(16'h0000, 16, "R7 chan", "R4 frame", "R3 ctrl");
    // mid-sweep rewrite of coding/pm with a foreign address
    frame(mk(1, 1, 7, 0, 0, 1, 0), 16, "R8 chan", "R4 frame", "R8 ctrl");
    for (int i = 0; i < 5; i++) frame(16'h0000, 16, "R8 chan", "R5 twos", "R8 ctrl");
    // aborted write frame
    frame(mk(1, 0, 1, 3, 0, 0, 1), 9, "R10 chan", "", "R10 ctrl");
    frame(16'h0000, 16, "R10 chan", "R4 frame", "R10 ctrl");
    // sweep over channel 0 only
    frame(mk(1, 1, 0, 1, 1, 0, 1), 16, "R7 chan", "R4 frame", "R9 ctrl");
    for (int i = 0; i < 3; i++) frame(16'h0000, 16, "R7 chan", "R5 straight", "R3 ctrl");

    for (int n = 0; n < 300; n++) begin
      logic [15:0] w = 16'($urandom);
      int r = int'($urandom % 16);
      w[13] = 1'b0; w[6] = 1'b0; w[3:0] = '0;
      w[15] = (r < 12);
      if (r == 15) frame(w, 1 + int'($urandom % 15), "R10 chan", "", "R10 ctrl");
      else frame(w, 16, "R11 chan", "R4 frame", "R9 ctrl");
      if ($urandom % 4 == 0) @(negedge clk_i);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule